// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is a 16-bit timer counter with a single compare channel. It is set up through a one-byte control register. The counter can run as a plain up-counter or a plain down-counter. It can also run in one of three center-aligned modes, where it sweeps from zero up to the auto-reload value and back down again.

An update event is raised when the counter wraps or turns, or when software pulses an update-generate strobe. At an update event the buffered auto-reload value is loaded, the update flag may be raised, and a one-shot run stops the counter. Update events can be suppressed entirely. The strobe can also be excluded from raising the update flag.

Software reaches the registers through a small write port and a read port. The read port returns data one clock after the address is presented. A sticky update flag and a sticky compare flag are driven out as interrupt sources. Writing ones to the flag register clears them.

Top module: `updown_timer_core`

## Requirements
- R1: After reset the control byte reads 0, the count reads 0, the auto-reload reads 0xFFFF, the compare value reads 0 and both flags are 0. Register addresses are: 0 control, 1 auto-reload, 2 compare, 3 flags (bit 0 update, bit 1 compare, write 1 to clear), 4 count (read only). rd_data shows the register at rd_addr one clock later.
- R2: The control byte bits are: 0 run, 1 update disable, 2 update-flag source, 3 one-shot, 4 direction (1 = down), 6:5 alignment mode, 7 auto-reload buffering. In edge-aligned mode a written control byte reads back unchanged.
- R3: In edge-aligned mode with direction 0, each enabled clock adds one to the count. When the count is at or above the auto-reload value it returns to 0 instead, which is an overflow update event.
- R4: In edge-aligned mode with direction 1, each enabled clock subtracts one from the count. At 0 it loads the auto-reload value that is in effect after the event, which is an underflow update event.
- R5: In modes 01, 10 and 11 the count climbs from 0 to the auto-reload value and then falls back to 0. Each turning point is an update event. Control bit 4 reads back the present counting direction.
- R6: The compare flag sets one clock after an enabled clock on which the count equals the compare value and the direction is allowed. Edge mode and mode 11 allow both directions, mode 01 allows only falling, and mode 10 allows only rising.
- R7: With one-shot set, any update event clears the run bit, and the counter stops.
- R8: Counter update events always set the update flag. A strobe-generated update event sets the flag only when the update-flag source bit is 0.
- R9: The update-generate strobe sets the count to 0 when counting up, or to the buffered auto-reload value when counting down, whether or not the counter runs.
- R10: With update disable set, no update event occurs: the strobe has no effect, the update flag does not rise, and the counter still wraps.
- R11: With buffering off, an auto-reload write takes effect at once. With buffering on, it takes effect only at the next update event.
- R12: While running in edge-aligned mode, a control write that selects a center-aligned mode leaves the alignment field unchanged.
- R13: Writing 1 to a bit of the flag register clears that flag. A flag being set in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data |
| sw_upd | input | 1 | Software update-generate strobe |
| upd_flag | output | 1 | Sticky update interrupt flag |
| cmp_flag | output | 1 | Sticky compare interrupt flag |

## Verification
The bench checks the turning points of each mode.
- An off-by-one at the top or at zero would shift the final count.
- A flag gate with its directions swapped would set the compare flag on the wrong leg of a center-aligned sweep.
- Buffered reload is checked with a period change whose early and late loads give different counts, so an unbuffered design would be caught.

The bench also exercises:
- the strobe under both flag-source settings and under update disable, where a leaky design would reset the count or raise the flag;
- the blocked switch into center-aligned mode while running;
- the direction readback after a turn.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

  typedef enum logic [1:0] {
    ALIGN_EDGE = 2'b00,
    CTR_DN     = 2'b01,
    CTR_UP     = 2'b10,
    CTR_BOTH   = 2'b11
  } align_e;

  typedef struct packed {
    logic   arbuf;
    align_e align;
    logic   dir;
    logic   one_shot;
    logic   upd_src;
    logic   upd_off;
    logic   run;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              run_clr,
  output ctrl_t             ctrl,
  output logic [CW-1:0]     reload_buf,
  output logic [CW-1:0]     cmp_val,
  output logic              reload_wr_now
);
  logic  ctrl_wr;
  ctrl_t ctrl_nxt;

  assign ctrl_wr       = wr_en && (wr_addr == A_CTRL);
  assign reload_wr_now = wr_en && (wr_addr == A_RELOAD) && !ctrl.arbuf;

  always_comb begin
    ctrl_nxt = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (ctrl.run && ctrl.align == ALIGN_EDGE && ctrl_nxt.align != ALIGN_EDGE)
      ctrl_nxt.align = ctrl.align;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl <= ctrl_nxt;
    end else if (run_clr) begin
      ctrl.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_buf <= '1;
      cmp_val    <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_RELOAD) reload_buf <= wr_data;
      if (wr_addr == A_CMP)    cmp_val    <= wr_data;
    end
  end

  // R12
  align_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl.run && ctrl.align == ALIGN_EDGE) |=> ctrl.align == ALIGN_EDGE);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl,
  input  logic          sw_upd,
  input  logic          reload_wr_now,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] reload_buf,
  output logic [CW-1:0] count,
  output logic          down_now,
  output logic          uev_hw,
  output logic          uev_sw
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          dir_q, dir_n;
  logic          center, turn, uev;
  logic [CW-1:0] reload_act, reload_ld, cnt_n;

  assign center    = ctrl.align != ALIGN_EDGE;
  assign down_now  = center ? dir_q : ctrl.dir;
  assign turn      = down_now ? (count == '0) : (count >= reload_act);
  assign uev_hw    = ctrl.run && turn && !ctrl.upd_off;
  assign uev_sw    = sw_upd && !ctrl.upd_off;
  assign uev       = uev_hw || uev_sw;
  assign reload_ld = uev ? reload_buf : reload_act;

  always_comb begin
    cnt_n = count;
    dir_n = center ? dir_q : 1'b0;
    if (uev_sw) begin
      cnt_n = down_now ? reload_buf : '0;
    end else if (ctrl.run) begin
      if (!center) begin
        if (down_now) cnt_n = turn ? reload_ld : count - ONE;
        else          cnt_n = turn ? '0 : count + ONE;
      end else if (!down_now) begin
        if (turn) begin
          dir_n = 1'b1;
          cnt_n = (count == '0) ? '0 : count - ONE;
        end else begin
          cnt_n = count + ONE;
        end
      end else begin
        if (turn) begin
          dir_n = 1'b0;
          cnt_n = (reload_ld == '0) ? '0 : ONE;
        end else begin
          cnt_n = count - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      dir_q      <= 1'b0;
      reload_act <= '1;
    end else begin
      count <= cnt_n;
      dir_q <= dir_n;
      if (reload_wr_now) reload_act <= wr_data;
      else if (uev)      reload_act <= reload_buf;
    end
  end

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.run && !center && !down_now && !sw_upd && count < reload_act)
      |=> count == $past(count) + ONE);

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.run && !center && down_now && !sw_upd && count != '0)
      |=> count == $past(count) - ONE);

  // R9
  strobe_up_chk: assert property (@(posedge clk) disable iff (rst)
    (uev_sw && !down_now) |=> count == '0);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl,
  input  logic          down_now,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp_val,
  input  logic          uev_hw,
  input  logic          uev_sw,
  input  logic          clr_wr,
  input  logic [1:0]    clr_bits,
  output logic          upd_flag,
  output logic          cmp_flag
);
  logic dir_ok, match, upd_set;

  always_comb begin
    unique case (ctrl.align)
      CTR_DN:  dir_ok = down_now;
      CTR_UP:  dir_ok = !down_now;
      default: dir_ok = 1'b1;
    endcase
  end

  assign match   = ctrl.run && (count == cmp_val) && dir_ok;
  assign upd_set = uev_hw || (uev_sw && !ctrl.upd_src);

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (upd_set)                  upd_flag <= 1'b1;
      else if (clr_wr && clr_bits[0]) upd_flag <= 1'b0;
      if (match)                    cmp_flag <= 1'b1;
      else if (clr_wr && clr_bits[1]) cmp_flag <= 1'b0;
    end
  end

  // R10
  upd_off_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.upd_off |=> !$rose(upd_flag));

  // R8
  upd_src_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.upd_src && !uev_hw) |=> !$rose(upd_flag));

  // R6
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.align == CTR_UP && down_now) |=> !$rose(cmp_flag));

  // R6
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.align == CTR_DN && !down_now) |=> !$rose(cmp_flag));
endmodule

// File: rtl/updown_timer_core.sv
module updown_timer_core
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  input  logic              sw_upd,
  output logic              upd_flag,
  output logic              cmp_flag
);
  ctrl_t         ctrl, ctrl_rd;
  logic [CW-1:0] reload_buf, cmp_val, count;
  logic          reload_wr_now, down_now, uev_hw, uev_sw, run_clr, ctrl_wr;

  assign run_clr = ctrl.one_shot && (uev_hw || uev_sw);
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  tmr_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_clr(run_clr), .ctrl(ctrl), .reload_buf(reload_buf), .cmp_val(cmp_val),
    .reload_wr_now(reload_wr_now)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .ctrl(ctrl), .sw_upd(sw_upd),
    .reload_wr_now(reload_wr_now), .wr_data(wr_data), .reload_buf(reload_buf),
    .count(count), .down_now(down_now), .uev_hw(uev_hw), .uev_sw(uev_sw)
  );

  tmr_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .ctrl(ctrl), .down_now(down_now), .count(count),
    .cmp_val(cmp_val), .uev_hw(uev_hw), .uev_sw(uev_sw),
    .clr_wr(wr_en && (wr_addr == A_FLAGS)), .clr_bits(wr_data[1:0]),
    .upd_flag(upd_flag), .cmp_flag(cmp_flag)
  );

  always_comb begin
    ctrl_rd = ctrl;
    if (ctrl.align != ALIGN_EDGE) ctrl_rd.dir = down_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        A_CTRL:   rd_data <= {{(CW-CTRL_W){1'b0}}, ctrl_rd};
        A_RELOAD: rd_data <= reload_buf;
        A_CMP:    rd_data <= cmp_val;
        A_FLAGS:  rd_data <= {{(CW-2){1'b0}}, cmp_flag, upd_flag};
        A_COUNT:  rd_data <= count;
        default:  rd_data <= '0;
      endcase
    end
  end

  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.one_shot && (uev_hw || uev_sw) && !ctrl_wr) |=> !ctrl.run);
endmodule

// File: tb/tb_updown_timer_core.sv
module tb_updown_timer_core;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        sw_upd = 1'b0;
  logic        upd_flag, cmp_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  updown_timer_core dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sw_upd(sw_upd),
    .upd_flag(upd_flag), .cmp_flag(cmp_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // control, reload, compare, counting clocks, expected count, update flag, compare flag
  localparam logic [7:0]  V_CTRL [NV] = '{8'h01, 8'h01, 8'h11, 8'h09, 8'h61,
                                          8'h21, 8'h21, 8'h41, 8'h03, 8'h01};
  localparam logic [15:0] V_ARR  [NV] = '{9, 4, 6, 3, 3, 3, 3, 3, 2, 2};
  localparam logic [15:0] V_CMP  [NV] = '{3, 7, 5, 2, 1, 1, 3, 3, 9, 9};
  localparam int          V_K    [NV] = '{5, 7, 4, 8, 8, 6, 4, 4, 5, 4};
  localparam logic [15:0] V_CNT  [NV] = '{5, 2, 3, 0, 2, 0, 2, 2, 2, 1};
  localparam logic        V_UPD  [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam logic        V_CMPF [NV] = '{1, 0, 1, 1, 1, 1, 0, 1, 0, 0};
  localparam string       V_REQ  [NV] = '{"R3", "R3", "R4", "R7", "R5",
                                          "R6", "R6", "R6", "R10", "R11"};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse();
    sw_upd = 1'b1;
    @(negedge clk);
    sw_upd = 1'b0;
  endtask

  // start with ctrl, stop with stop value; exactly k counting clocks
  task automatic run(input logic [7:0] c, input int k, input logic [7:0] stop);
    wr(3'd0, {8'h00, c});
    repeat (k - 1) @(negedge clk);
    wr(3'd0, {8'h00, stop});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(3'd4, v); check("R1 count", v, 16'h0000);
    rd(3'd1, v); check("R1 reload", v, 16'hFFFF);
    rd(3'd2, v); check("R1 compare", v, 16'h0000);
    check("R1 flags", {14'd0, cmp_flag, upd_flag}, 16'h0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      if (i == NV - 1) begin
        // R11 unbuffered reload applies immediately while running
        wr(3'd1, 16'd7);
        wr(3'd2, V_CMP[i]);
        wr(3'd0, 16'h0001);
        wr(3'd1, V_ARR[i]);
        repeat (V_K[i] - 2) @(negedge clk);
        wr(3'd0, 16'h0000);
      end else begin
        wr(3'd1, V_ARR[i]);
        wr(3'd2, V_CMP[i]);
        run(V_CTRL[i], V_K[i], V_CTRL[i] & 8'hFE);
      end
      check({V_REQ[i], " upd"}, {15'd0, upd_flag}, {15'd0, V_UPD[i]});
      check({V_REQ[i], " cmp"}, {15'd0, cmp_flag}, {15'd0, V_CMPF[i]});
      rd(3'd4, v); check({V_REQ[i], " count"}, v, V_CNT[i]);
    end

    // R2 control layout readback
    do_reset();
    wr(3'd0, 16'h009E);
    rd(3'd0, v); check("R2 ctrl readback", v, 16'h009E);

    // R12 mode switch blocked while running
    do_reset();
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h0021);
    rd(3'd0, v); check("R12 blocked", v, 16'h0001);
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0020);
    rd(3'd0, v); check("R12 allowed when stopped", v, 16'h0020);

    // R9 / R8 / R13 strobe behaviour
    do_reset();
    wr(3'd1, 16'd5);
    run(8'h01, 3, 8'h00);
    rd(3'd4, v); check("R3 pre-strobe count", v, 16'd3);
    pulse();
    rd(3'd4, v); check("R9 strobe up resets to 0", v, 16'd0);
    check("R8 strobe sets flag", {15'd0, upd_flag}, 16'd1);
    wr(3'd3, 16'h0003);
    check("R13 clear", {15'd0, upd_flag}, 16'd0);
    wr(3'd0, 16'h0004);
    pulse();
    check("R8 source excludes strobe", {15'd0, upd_flag}, 16'd0);
    wr(3'd0, 16'h0010);
    pulse();
    rd(3'd4, v); check("R9 strobe down loads reload", v, 16'd5);

    // R10 strobe ignored with update disable
    do_reset();
    wr(3'd1, 16'd9);
    run(8'h03, 3, 8'h02);
    pulse();
    rd(3'd4, v); check("R10 strobe ignored count", v, 16'd3);
    check("R10 strobe ignored flag", {15'd0, upd_flag}, 16'd0);

    // R11 buffered reload waits for update event
    do_reset();
    wr(3'd0, 16'h0080);
    wr(3'd1, 16'd5);
    pulse();
    wr(3'd1, 16'd2);
    run(8'h81, 4, 8'h80);
    rd(3'd4, v); check("R11 buffered count", v, 16'd4);

    // R5 direction readback after top turn
    do_reset();
    wr(3'd1, 16'd3);
    run(8'h61, 5, 8'h60);
    rd(3'd0, v); check("R5 dir readback", v, 16'h0070);
    rd(3'd4, v); check("R5 count after turn", v, 16'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule